// File: doc/BRIEF.md
# Interrupt Stacking and Vectoring Sequencer

This block runs the bus cycles that take a small 8-bit CPU with a 16-bit address bus into a hardware interrupt handler and back out again. The core raises `boundary_i` when an instruction has just finished. At that point the sequencer looks at the pending requests, the per-source enables and the interrupt mask bit of the condition code register. If service is allowed, it copies the register context and stalls the core with `busy_o`. It then spends one cycle on a dummy read and saves the context on a stack that grows downward. It loads the condition code register with the mask set, reads a 16-bit vector and hands that vector to the program counter.

When the core decodes a return-from-interrupt it raises `rti_i` instead. The sequencer then reads the context back from ascending stack addresses and drives a load strobe for each register. If the restored mask bit is clear and an enabled request is still pending at the end of the return, a new entry starts in the next cycle with no gap. The core never executes the instruction that follows the return in that case. The sequencer issues exactly one byte transfer per clock while busy. Memory read data is combinational: it is returned in the same cycle as the address.

Top module: `irq_seq`

## Requirements
- R1: Requests are evaluated only in an idle cycle with `boundary_i` high. With neither `boundary_i` nor `rti_i` high, the sequencer stays idle whatever the requests are.
- R2: An entry starts only if bit 3 of `ccr_i` (the mask bit, 1 = masked) is 0 and at least one source has both its request and its enable bit at 1. Otherwise `busy_o` stays low.
- R3: Of several enabled pending sources, the lowest-numbered one wins. Source i reads its vector high byte at address VEC_TOP−2·i and its low byte at VEC_TOP−2·i+1.
- R4: The first busy cycle of an entry is a read at the saved PC. The next five cycles are writes (`rw_o` = 0): PC low at SP, PC high at SP−1, X at SP−2, A at SP−3, and CCR as it was before entry at SP−4.
- R5: In the cycle that writes CCR, `ld_ccr_o` is high with `ccr_o` equal to the saved CCR with bit 3 set. In the same cycle `ld_sp_o` is high with `sp_o` = SP−5.
- R6: The two cycles after the pushes are reads of the vector high byte and then the vector low byte. In the low-byte cycle `ld_pc_o` is high with `pc_o` = {high, low}. `busy_o` is high for exactly 8 cycles and `ld_pc_o` is never high in two cycles running.
- R7: With `rti_i` high in an idle cycle, the next five cycles read SP+1 to SP+5. The strobes are, in this order: `ld_ccr_o`, `ld_a_o`, `ld_x_o`, no strobe (PC high byte), then `ld_pc_o` with `ld_sp_o` = SP+5. `busy_o` then falls unless R8 applies.
- R8: If the restored CCR has bit 3 clear and an enabled request is pending in the last return cycle, `busy_o` stays high and the next cycle is the dummy read of a new entry at the restored PC, with stacking at the restored SP+5. If bit 3 is set, the return ends normally.
- R9: During reset and in every idle cycle, the bus is in read mode and all load strobes are low.
- R10: While busy, `boundary_i` and `rti_i` have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| rti_i | input | 1 | Core requests return from interrupt |
| irq_req_i | input | NUM_SRC | Pending requests, bit 0 highest priority |
| irq_en_i | input | NUM_SRC | Per-source enables |
| pc_i | input | 16 | Address of the next instruction |
| sp_i | input | 16 | Stack pointer |
| a_i | input | 8 | Accumulator |
| x_i | input | 8 | Index register |
| ccr_i | input | 8 | Condition code register, bit 3 = mask |
| addr_o | output | 16 | Bus address |
| rw_o | output | 1 | 1 = read, 0 = write |
| wdata_o | output | 8 | Write data |
| rdata_i | input | 8 | Read data, same cycle |
| busy_o | output | 1 | Stall the core |
| ld_pc_o | output | 1 | Load PC strobe |
| pc_o | output | 16 | New PC value |
| ld_sp_o | output | 1 | Load SP strobe |
| sp_o | output | 16 | New SP value |
| ld_a_o | output | 1 | Load A strobe |
| a_o | output | 8 | New A value |
| ld_x_o | output | 1 | Load X strobe |
| x_o | output | 8 | New X value |
| ld_ccr_o | output | 1 | Load CCR strobe |
| ccr_o | output | 8 | New CCR value |

## Verification
The bench builds the block with NUM_SRC = 4 and VEC_TOP = 16'hFFFE, so the four vector pairs are at FFFE down to FFF8. Four sources are enough to exercise three cases: the highest-priority source being disabled while a lower one wins, a middle source winning over a lower one, and the lowest-priority source being reached through a chained return. The vector bytes come from a fixed function of the address, so each source yields a different PC.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int MASK_BIT = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DUMMY,
        S_PUSH_PCL,
        S_PUSH_PCH,
        S_PUSH_X,
        S_PUSH_A,
        S_PUSH_CCR,
        S_VEC_HI,
        S_VEC_LO,
        S_POP_CCR,
        S_POP_A,
        S_POP_X,
        S_POP_PCH,
        S_POP_PCL
    } seq_state_e;

    typedef struct packed {
        seq_state_e  st;
        logic [15:0] pc;
        logic [7:0]  a;
        logic [7:0]  x;
        logic [7:0]  ccr;
        logic [15:0] sp;
        logic [15:0] vaddr;
        logic [7:0]  vhi;
    } seq_regs_t;

endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int NUM_SRC = 4,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC:0]   above;
    logic [NUM_SRC-1:0] grant;

    assign active   = req_i & en_i;
    assign above[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign above[g+1] = above[g] | active[g];
        assign grant[g]   = active[g] & ~above[g];
    end

    assign any_o = above[NUM_SRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_vaddr.sv
module irq_vaddr #(
    parameter int          NUM_SRC = 4,
    parameter logic [15:0] VEC_TOP = 16'hFFFE,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [15:0]      addr_o
);
    logic [15:0] offset;
    assign offset = {{(16-IDX_W){1'b0}}, idx_i} << 1;
    assign addr_o = VEC_TOP - offset;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int          NUM_SRC = 4,
    parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic               rti_i,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic [NUM_SRC-1:0] irq_en_i,
    input  logic [15:0]        pc_i,
    input  logic [15:0]        sp_i,
    input  logic [7:0]         a_i,
    input  logic [7:0]         x_i,
    input  logic [7:0]         ccr_i,
    output logic [15:0]        addr_o,
    output logic               rw_o,
    output logic [7:0]         wdata_o,
    input  logic [7:0]         rdata_i,
    output logic               busy_o,
    output logic               ld_pc_o,
    output logic [15:0]        pc_o,
    output logic               ld_sp_o,
    output logic [15:0]        sp_o,
    output logic               ld_a_o,
    output logic [7:0]         a_o,
    output logic               ld_x_o,
    output logic [7:0]         x_o,
    output logic               ld_ccr_o,
    output logic [7:0]         ccr_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [7:0] MASK = 8'(1) << MASK_BIT;

    seq_regs_t r_q, r_d;

    logic             irq_any;
    logic [IDX_W-1:0] irq_idx;
    logic [15:0]      vec_addr;

    irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .req_i (irq_req_i),
        .en_i  (irq_en_i),
        .any_o (irq_any),
        .idx_o (irq_idx)
    );

    irq_vaddr #(.NUM_SRC(NUM_SRC), .VEC_TOP(VEC_TOP)) u_vaddr (
        .idx_i  (irq_idx),
        .addr_o (vec_addr)
    );

    always_comb begin
        r_d      = r_q;
        addr_o   = 16'h0000;
        rw_o     = 1'b1;
        wdata_o  = 8'h00;
        ld_pc_o  = 1'b0;
        pc_o     = 16'h0000;
        ld_sp_o  = 1'b0;
        sp_o     = 16'h0000;
        ld_a_o   = 1'b0;
        a_o      = 8'h00;
        ld_x_o   = 1'b0;
        x_o      = 8'h00;
        ld_ccr_o = 1'b0;
        ccr_o    = 8'h00;

        unique case (r_q.st)
            S_IDLE: begin
                if (rti_i) begin
                    r_d.st = S_POP_CCR;
                    r_d.sp = sp_i;
                end else if (boundary_i && !ccr_i[MASK_BIT] && irq_any) begin
                    r_d.st    = S_DUMMY;
                    r_d.pc    = pc_i;
                    r_d.a     = a_i;
                    r_d.x     = x_i;
                    r_d.ccr   = ccr_i;
                    r_d.sp    = sp_i;
                    r_d.vaddr = vec_addr;
                end
            end
            S_DUMMY: begin
                addr_o = r_q.pc;
                r_d.st = S_PUSH_PCL;
            end
            S_PUSH_PCL: begin
                addr_o  = r_q.sp;
                rw_o    = 1'b0;
                wdata_o = r_q.pc[7:0];
                r_d.st  = S_PUSH_PCH;
            end
            S_PUSH_PCH: begin
                addr_o  = r_q.sp - 16'd1;
                rw_o    = 1'b0;
                wdata_o = r_q.pc[15:8];
                r_d.st  = S_PUSH_X;
            end
            S_PUSH_X: begin
                addr_o  = r_q.sp - 16'd2;
                rw_o    = 1'b0;
                wdata_o = r_q.x;
                r_d.st  = S_PUSH_A;
            end
            S_PUSH_A: begin
                addr_o  = r_q.sp - 16'd3;
                rw_o    = 1'b0;
                wdata_o = r_q.a;
                r_d.st  = S_PUSH_CCR;
            end
            S_PUSH_CCR: begin
                addr_o   = r_q.sp - 16'd4;
                rw_o     = 1'b0;
                wdata_o  = r_q.ccr;
                ld_ccr_o = 1'b1;
                ccr_o    = r_q.ccr | MASK;
                ld_sp_o  = 1'b1;
                sp_o     = r_q.sp - 16'd5;
                r_d.st   = S_VEC_HI;
            end
            S_VEC_HI: begin
                addr_o  = r_q.vaddr;
                r_d.vhi = rdata_i;
                r_d.st  = S_VEC_LO;
            end
            S_VEC_LO: begin
                addr_o  = r_q.vaddr + 16'd1;
                ld_pc_o = 1'b1;
                pc_o    = {r_q.vhi, rdata_i};
                r_d.st  = S_IDLE;
            end
            S_POP_CCR: begin
                addr_o   = r_q.sp + 16'd1;
                ld_ccr_o = 1'b1;
                ccr_o    = rdata_i;
                r_d.ccr  = rdata_i;
                r_d.st   = S_POP_A;
            end
            S_POP_A: begin
                addr_o = r_q.sp + 16'd2;
                ld_a_o = 1'b1;
                a_o    = rdata_i;
                r_d.a  = rdata_i;
                r_d.st = S_POP_X;
            end
            S_POP_X: begin
                addr_o = r_q.sp + 16'd3;
                ld_x_o = 1'b1;
                x_o    = rdata_i;
                r_d.x  = rdata_i;
                r_d.st = S_POP_PCH;
            end
            S_POP_PCH: begin
                addr_o        = r_q.sp + 16'd4;
                r_d.pc[15:8]  = rdata_i;
                r_d.st        = S_POP_PCL;
            end
            S_POP_PCL: begin
                addr_o       = r_q.sp + 16'd5;
                ld_pc_o      = 1'b1;
                pc_o         = {r_q.pc[15:8], rdata_i};
                ld_sp_o      = 1'b1;
                sp_o         = r_q.sp + 16'd5;
                r_d.pc[7:0]  = rdata_i;
                r_d.sp       = r_q.sp + 16'd5;
                if (!r_q.ccr[MASK_BIT] && irq_any) begin
                    r_d.st    = S_DUMMY;
                    r_d.vaddr = vec_addr;
                end else begin
                    r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= S_IDLE;
            r_q.ccr <= MASK;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st != S_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
    import irq_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       boundary_i,
    input logic       rti_i,
    input logic [7:0] ccr_i,
    input logic       busy_o,
    input logic       rw_o,
    input logic       ld_pc_o,
    input logic       ld_sp_o,
    input logic       ld_ccr_o,
    input logic [7:0] ccr_o
);
    a_r1_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !boundary_i && !rti_i) |=> !busy_o);

    a_r2_masked_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && boundary_i && !rti_i && ccr_i[MASK_BIT]) |=> !busy_o);

    a_r4_dummy_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> rw_o);

    a_r5_mask_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ccr_o && !rw_o) |-> ccr_o[MASK_BIT]);

    a_r6_single_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pc_o |=> !ld_pc_o);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rw_o && !ld_pc_o && !ld_ccr_o && !ld_sp_o));
endmodule

bind irq_seq irq_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .rti_i      (rti_i),
    .ccr_i      (ccr_i),
    .busy_o     (busy_o),
    .rw_o       (rw_o),
    .ld_pc_o    (ld_pc_o),
    .ld_sp_o    (ld_sp_o),
    .ld_ccr_o   (ld_ccr_o),
    .ccr_o      (ccr_o)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
    localparam int          N   = 4;
    localparam logic [15:0] TOP = 16'hFFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0, rti_i = 1'b0;
    logic [N-1:0] irq_req_i = '0, irq_en_i = '0;
    logic [15:0] pc_i = '0, sp_i = '0;
    logic [7:0]  a_i = '0, x_i = '0, ccr_i = 8'h08;
    logic [15:0] addr_o, pc_o, sp_o;
    logic        rw_o, busy_o, ld_pc_o, ld_sp_o, ld_a_o, ld_x_o, ld_ccr_o;
    logic [7:0]  wdata_o, rdata_i, a_o, x_o, ccr_o;

    logic [7:0] stk [256];
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_seq #(.NUM_SRC(N), .VEC_TOP(TOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .rti_i(rti_i),
        .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .pc_i(pc_i), .sp_i(sp_i),
        .a_i(a_i), .x_i(x_i), .ccr_i(ccr_i), .addr_o(addr_o), .rw_o(rw_o),
        .wdata_o(wdata_o), .rdata_i(rdata_i), .busy_o(busy_o),
        .ld_pc_o(ld_pc_o), .pc_o(pc_o), .ld_sp_o(ld_sp_o), .sp_o(sp_o),
        .ld_a_o(ld_a_o), .a_o(a_o), .ld_x_o(ld_x_o), .x_o(x_o),
        .ld_ccr_o(ld_ccr_o), .ccr_o(ccr_o)
    );

    function automatic logic [7:0] vbyte(input logic [15:0] ad);
        return ad[7:0] ^ 8'hA5;
    endfunction

    function automatic logic [15:0] vec_pc(input int src);
        logic [15:0] va;
        va = TOP - 16'(2 * src);
        return {vbyte(va), vbyte(va + 16'd1)};
    endfunction

    assign rdata_i = (addr_o[15:8] == 8'hFF) ? vbyte(addr_o) : stk[addr_o[7:0]];

    always @(posedge clk) begin
        if (busy_o && !rw_o) stk[addr_o[7:0]] <= wdata_o;
    end

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Called at the negedge where the dummy read is visible.
    task automatic entry_body(input logic [15:0] pc, input logic [15:0] sp,
                              input logic [7:0] a, input logic [7:0] x,
                              input logic [7:0] ccr, input int src);
        logic [7:0] data [5];
        logic [15:0] va;
        data[0] = pc[7:0]; data[1] = pc[15:8]; data[2] = x; data[3] = a; data[4] = ccr;
        va = TOP - 16'(2 * src);
        chk("R4", "dummy busy", busy_o, 1);
        chk("R4", "dummy rw", rw_o, 1);
        chk("R4", "dummy addr", addr_o, pc);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R4", "push rw", rw_o, 0);
            chk("R4", "push addr", addr_o, sp - 16'(k));
            chk("R4", "push data", wdata_o, data[k]);
            chk("R5", "ccr strobe", ld_ccr_o, (k == 4));
            chk("R5", "sp strobe", ld_sp_o, (k == 4));
            if (k == 4) begin
                chk("R5", "ccr masked", ccr_o, ccr | 8'h08);
                chk("R5", "sp value", sp_o, sp - 16'd5);
            end
        end
        @(negedge clk);
        chk("R3", "vec hi addr", addr_o, va);
        chk("R6", "vec hi rw", rw_o, 1);
        chk("R6", "no pc load yet", ld_pc_o, 0);
        @(negedge clk);
        chk("R3", "vec lo addr", addr_o, va + 16'd1);
        chk("R6", "pc load", ld_pc_o, 1);
        chk("R6", "pc value", pc_o, vec_pc(src));
        rti_i = 1'b0;
        boundary_i = 1'b0;
        @(negedge clk);
        chk("R6", "busy end", busy_o, 0);
        chk("R6", "pc strobe drops", ld_pc_o, 0);
    endtask

    task automatic t_entry(input logic [N-1:0] req, input logic [N-1:0] en,
                           input logic [15:0] pc, input logic [15:0] sp,
                           input logic [7:0] a, input logic [7:0] x,
                           input logic [7:0] ccr, input int src, input bit noise);
        irq_req_i = req; irq_en_i = en; pc_i = pc; sp_i = sp;
        a_i = a; x_i = x; ccr_i = ccr; boundary_i = 1'b1;
        @(negedge clk);
        // R10: when noise is set, boundary_i and rti_i stay high while busy
        boundary_i = noise;
        rti_i = noise;
        ccr_i = ccr | 8'h08;
        pc_i = 16'hDEAD; sp_i = 16'h0000;
        entry_body(pc, sp, a, x, ccr, src);
        irq_req_i = '0;
    endtask

    task automatic t_return(input logic [15:0] sp, input logic [7:0] ccr,
                            input logic [7:0] a, input logic [7:0] x,
                            input logic [15:0] pc, input bit chain);
        sp_i = sp; rti_i = 1'b1;
        @(negedge clk);
        rti_i = 1'b0; sp_i = 16'h0000;
        chk("R7", "pop ccr addr", addr_o, sp + 16'd1);
        chk("R7", "pop ccr rw", rw_o, 1);
        chk("R7", "pop ccr strobe", ld_ccr_o, 1);
        chk("R7", "pop ccr value", ccr_o, ccr);
        @(negedge clk);
        chk("R7", "pop a addr", addr_o, sp + 16'd2);
        chk("R7", "pop a", {ld_a_o, a_o}, {1'b1, a});
        @(negedge clk);
        chk("R7", "pop x addr", addr_o, sp + 16'd3);
        chk("R7", "pop x", {ld_x_o, x_o}, {1'b1, x});
        @(negedge clk);
        chk("R7", "pop pch addr", addr_o, sp + 16'd4);
        chk("R7", "pch no strobe", {ld_pc_o, ld_a_o, ld_x_o, ld_ccr_o}, 0);
        @(negedge clk);
        chk("R7", "pop pcl addr", addr_o, sp + 16'd5);
        chk("R7", "pc load", {ld_pc_o, pc_o}, {1'b1, pc});
        chk("R7", "sp load", {ld_sp_o, sp_o}, {1'b1, sp + 16'd5});
        @(negedge clk);
        if (chain) begin
            chk("R8", "chain busy", busy_o, 1);
            chk("R8", "chain dummy addr", addr_o, pc);
        end else begin
            chk("R7", "return busy end", busy_o, 0);
        end
    endtask

    task automatic t_no_take(input string rq, input bit bnd, input logic [7:0] ccr,
                             input logic [N-1:0] req, input logic [N-1:0] en);
        irq_req_i = req; irq_en_i = en; ccr_i = ccr; boundary_i = bnd;
        pc_i = 16'h4444; sp_i = 16'h0080;
        repeat (3) begin
            @(negedge clk);
            chk(rq, "stays idle", busy_o, 0);
            chk("R9", "idle bus read", rw_o, 1);
        end
        boundary_i = 1'b0; irq_req_i = '0;
    endtask

    task automatic t_reset_mid;
        irq_req_i = 4'b0001; irq_en_i = 4'b0001; ccr_i = 8'h00;
        pc_i = 16'h0100; sp_i = 16'h0070; boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0; irq_req_i = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "mid-sequence busy", busy_o, 1);
        rst_n = 1'b0;
        #1;
        chk("R9", "reset busy", busy_o, 0);
        chk("R9", "reset strobes", {ld_pc_o, ld_sp_o, ld_a_o, ld_x_o, ld_ccr_o}, 0);
        chk("R9", "reset rw", rw_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "after reset idle", busy_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (2) @(negedge clk);
        chk("R9", "reset busy", busy_o, 0);
        chk("R9", "reset rw", rw_o, 1);
        chk("R9", "reset strobes", {ld_pc_o, ld_sp_o, ld_a_o, ld_x_o, ld_ccr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        t_no_take("R2", 1'b1, 8'h68, 4'b0100, 4'b1111);   // masked
        t_no_take("R2", 1'b1, 8'h60, 4'b0100, 4'b1011);   // source disabled
        t_no_take("R1", 1'b0, 8'h60, 4'b0100, 4'b1111);   // no boundary

        // R4 R5 R6: single source 2
        t_entry(4'b0100, 4'b1111, 16'h1234, 16'h00F0, 8'h11, 8'h22, 8'h60, 2, 1'b0);
        // R3 R10: source 0 disabled, sources 1 and 3 pending, noise on inputs
        t_entry(4'b1011, 4'b1110, 16'h2345, 16'h00D0, 8'h33, 8'h44, 8'h61, 1, 1'b1);

        // R7: plain return from first frame
        ccr_i = 8'h68;
        t_return(16'h00EB, 8'h60, 8'h11, 8'h22, 16'h1234, 1'b0);

        // R8: chained entry to source 3 after return of second frame
        irq_req_i = 4'b1000; irq_en_i = 4'b1000;
        t_return(16'h00CB, 8'h61, 8'h33, 8'h44, 16'h2345, 1'b1);
        entry_body(16'h2345, 16'h00D0, 8'h33, 8'h44, 8'h61, 3);

        // R8: restored mask set, pending request must not chain
        stk[8'hB1] = 8'h68; stk[8'hB2] = 8'h01; stk[8'hB3] = 8'h02;
        stk[8'hB4] = 8'h40; stk[8'hB5] = 8'h00;
        irq_req_i = 4'b0001; irq_en_i = 4'b0001;
        t_return(16'h00B0, 8'h68, 8'h01, 8'h02, 16'h4000, 1'b0);
        irq_req_i = '0;

        t_reset_mid();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule